// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with High-Impedance Sampling

This block is the serial test port of a synchronous memory device. A tester drives a test clock, a mode select line and serial data. The port then shifts instructions and data through one of three data registers and returns serial data on an output that has its own enable. The data registers are a single-stage bypass register, a fixed 32-bit identification register and a 117-cell boundary register that sits around the device pins.

The boundary register observes internal values, the plain input pins, the bidirectional data pins and the core's own output data. It can take over the data pins when the instruction asks for it. One shared control cell gates the output enable of all eighteen data pins at once.

Besides the usual external-test, sample, identification and bypass instructions, the port has a sampling mode that holds every data pin at high impedance while the boundary register records the pins. The functional path (core data and core enable to the pins) passes through the block whenever the boundary register does not drive the pins.

Top module: `bscan_tap`

## Requirements
- R1: The controller follows the 16-state test-port state diagram, advancing on the rising test clock edge. Five consecutive rising edges with `tms` high reach the reset state from any state. `trst_n` low forces the reset state asynchronously.
- R2: In the reset state the active instruction becomes IDCODE. With IDCODE active, a data scan returns 0x000121B3 least significant bit first.
- R3: The instruction register is 3 bits wide and shifted least significant bit first. Capture-IR loads 3'b001, so the first bit shifted out is 1. A new instruction takes effect on the rising edge that leaves Update-IR.
- R4: Opcodes are given as ir[2:0]: 3'b000 EXTEST, 3'b100 SAMPLE, 3'b001 IDCODE, 3'b010 SAMPLZ, 3'b111 BYPASS. The codes 3'b011, 3'b101 and 3'b110 act as BYPASS.
- R5: The bypass register captures 0 and adds exactly one stage between `tdi` and `tdo`.
- R6: EXTEST, SAMPLE and SAMPLZ select the 117-cell boundary register, which shifts toward cell 0 (cell 0 nearest `tdo`). At capture, the cells load as follows:
  - cells 0..46 load `core_obs[i]`;
  - cells 47..79 load `pin_in[i-47]`;
  - for data pin k, cell 80+2k loads `core_dq_out[k]` and cell 81+2k loads `dq_pin_in[k]`;
  - cell 116 loads `core_dq_oe`.
- R7: Update-DR under any boundary instruction loads the update stage of each data output cell and of the control cell. Under SAMPLE the pins keep `core_dq_out` and `core_dq_oe`.
- R8: Under EXTEST, `dq_out[k]` is the update stage of cell 80+2k and `dq_oe` is the update stage of cell 116. A 0 in that stage turns all data outputs off.
- R9: Under SAMPLZ, `dq_oe` is 0 whatever the control cell holds, `dq_out` follows `core_dq_out`, and capture behaves as under SAMPLE.
- R10: `tdo` and `tdo_oe` change on the falling test clock edge. `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR.
- R11: `trst_n` low clears the update stages to 0, so EXTEST without a preceding data scan leaves the data outputs off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous test reset, active low |
| core_obs | input | 47 | Internal values observed by cells 0..46 |
| pin_in | input | 33 | Plain input pins observed by cells 47..79 |
| dq_pin_in | input | 18 | Bidirectional data pins as seen at the pad |
| core_dq_out | input | 18 | Core data toward the data pins |
| core_dq_oe | input | 1 | Core output enable for the data pins |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Enable for the serial data output |
| dq_out | output | 18 | Data driven to the data pins |
| dq_oe | output | 1 | Shared output enable for the data pins |

## Verification
The hardest case to reach is the five-edge reset from a state where four edges are not enough. The bench parks the controller in Pause-DR under BYPASS, so that the walk through Exit2, Update, Select-DR and Select-IR only reaches reset on the fifth edge. It then shows the identification code on the next data scan. The shared enable is the other difficult point. The bench scans patterns whose control bit is 1 and then 0, and it compares EXTEST, SAMPLE and SAMPLZ with the core enable held at 1. An asynchronous reset in the middle of EXTEST then shows that the update stages were cleared.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int unsigned IR_W = 3;
  localparam int unsigned ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLZ = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] { DR_BYP, DR_ID, DR_BSR } dr_sel_e;
  typedef enum logic [1:0] { PM_CORE, PM_EXT, PM_HIZ } pin_mode_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
      default:   return m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE, OP_SAMPLZ: return DR_BSR;
      OP_IDCODE:                       return DR_ID;
      default:                         return DR_BYP;
    endcase
  endfunction

  function automatic pin_mode_e pin_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST: return PM_EXT;
      OP_SAMPLZ: return PM_HIZ;
      default:   return PM_CORE;
    endcase
  endfunction

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end
endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        ST_RESET:  ir_q  <= OP_IDCODE;
        ST_CAP_IR: ir_sr <= IR_CAPTURE;
        ST_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sr;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int unsigned N_INT = 47,
  parameter int unsigned N_IN  = 33,
  parameter int unsigned N_DQ  = 18
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             tdi,
  input  logic [N_INT-1:0] core_obs,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_DQ-1:0]  dq_pin_in,
  input  logic [N_DQ-1:0]  core_dq_out,
  input  logic             core_dq_oe,
  output logic             ser_out,
  output logic [N_DQ-1:0]  upd_data,
  output logic             upd_ctrl
);
  localparam int unsigned IN_BASE = N_INT;
  localparam int unsigned DQ_BASE = IN_BASE + N_IN;
  localparam int unsigned CTL_IDX = DQ_BASE + 2 * N_DQ;
  localparam int unsigned LEN     = CTL_IDX + 1;

  logic [LEN-1:0]  cap_vec;
  logic [LEN-1:0]  sr;
  logic [N_DQ-1:0] out_cells;

  assign cap_vec[IN_BASE-1:0]       = core_obs;
  assign cap_vec[DQ_BASE-1:IN_BASE] = pin_in;
  assign cap_vec[CTL_IDX]           = core_dq_oe;

  for (genvar k = 0; k < N_DQ; k++) begin : g_dq
    assign cap_vec[DQ_BASE + 2*k]     = core_dq_out[k];
    assign cap_vec[DQ_BASE + 2*k + 1] = dq_pin_in[k];
    assign out_cells[k]               = sr[DQ_BASE + 2*k];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      sr <= '0;
    else if (capture) sr <= cap_vec;
    else if (shift)   sr <= {tdi, sr[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      upd_data <= '0;
      upd_ctrl <= 1'b0;
    end else if (update) begin
      upd_data <= out_cells;
      upd_ctrl <= sr[CTL_IDX];
    end
  end

  assign ser_out = sr[0];
endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int unsigned     N_INT    = 47,
  parameter int unsigned     N_IN     = 33,
  parameter int unsigned     N_DQ     = 18,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0001_21B3
) (
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             trst_n,
  input  logic [N_INT-1:0] core_obs,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_DQ-1:0]  dq_pin_in,
  input  logic [N_DQ-1:0]  core_dq_out,
  input  logic             core_dq_oe,
  output logic             tdo,
  output logic             tdo_oe,
  output logic [N_DQ-1:0]  dq_out,
  output logic             dq_oe
);
  tap_state_e      state;
  logic [IR_W-1:0] ir_sr, ir_q;
  logic [ID_W-1:0] id_sr;
  logic            byp_q;
  logic            bsr_ser;
  logic [N_DQ-1:0] upd_data;
  logic            upd_ctrl;
  dr_sel_e         dr_sel;
  pin_mode_e       pin_mode;

  // named events for the checker
  wire ev_cap_dr = (state == ST_CAP_DR);
  wire ev_shf_dr = (state == ST_SHF_DR);
  wire ev_upd_dr = (state == ST_UPD_DR);
  wire ev_shift  = ev_shf_dr || (state == ST_SHF_IR);

  assign dr_sel   = dr_decode(ir_q);
  assign pin_mode = pin_decode(ir_q);

  bscan_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  bscan_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_sr(ir_sr), .ir_q(ir_q)
  );

  bscan_chain #(.N_INT(N_INT), .N_IN(N_IN), .N_DQ(N_DQ)) u_chain (
    .tck(tck), .trst_n(trst_n),
    .capture(ev_cap_dr && dr_sel == DR_BSR),
    .shift(ev_shf_dr && dr_sel == DR_BSR),
    .update(ev_upd_dr && dr_sel == DR_BSR),
    .tdi(tdi), .core_obs(core_obs), .pin_in(pin_in), .dq_pin_in(dq_pin_in),
    .core_dq_out(core_dq_out), .core_dq_oe(core_dq_oe),
    .ser_out(bsr_ser), .upd_data(upd_data), .upd_ctrl(upd_ctrl)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= '0;
      byp_q <= 1'b0;
    end else begin
      if (ev_cap_dr && dr_sel == DR_ID)      id_sr <= ID_VALUE;
      else if (ev_shf_dr && dr_sel == DR_ID) id_sr <= {tdi, id_sr[ID_W-1:1]};
      if (ev_cap_dr && dr_sel == DR_BYP)      byp_q <= 1'b0;
      else if (ev_shf_dr && dr_sel == DR_BYP) byp_q <= tdi;
    end
  end

  logic ser_mux;
  always_comb begin
    if (state == ST_SHF_IR)      ser_mux = ir_sr[0];
    else if (dr_sel == DR_ID)    ser_mux = id_sr[0];
    else if (dr_sel == DR_BSR)   ser_mux = bsr_ser;
    else                         ser_mux = byp_q;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= ser_mux;
      tdo_oe <= ev_shift;
    end
  end

  always_comb begin
    case (pin_mode)
      PM_EXT: begin dq_out = upd_data;    dq_oe = upd_ctrl;   end
      PM_HIZ: begin dq_out = core_dq_out; dq_oe = 1'b0;       end
      default: begin dq_out = core_dq_out; dq_oe = core_dq_oe; end
    endcase
  end
endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
  import bscan_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sr,
  input logic            byp_q,
  input logic            ev_cap_dr,
  input logic            tdo_oe,
  input logic            dq_oe,
  input logic            upd_ctrl
);
  logic [2:0] ones_cnt;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        ones_cnt <= '0;
    else if (!tms)      ones_cnt <= '0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == ST_RESET));

  a_r2_reset_loads_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |=> (ir_q == OP_IDCODE));

  a_r3_capture_ir_pattern: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  a_r5_bypass_captures_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (ev_cap_dr && dr_decode(ir_q) == DR_BYP) |=> !byp_q);

  a_r8_extest_enable_from_ctrl: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == OP_EXTEST) |-> (dq_oe == upd_ctrl));

  a_r9_samplz_outputs_off: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == OP_SAMPLZ) |-> !dq_oe);

  a_r10_tdo_oe_only_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SHF_DR || state == ST_SHF_IR));
endmodule

bind bscan_tap bscan_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir_q(ir_q),
  .ir_sr(ir_sr), .byp_q(byp_q), .ev_cap_dr(ev_cap_dr), .tdo_oe(tdo_oe),
  .dq_oe(dq_oe), .upd_ctrl(upd_ctrl)
);

// File: tb/bscan_tap_tb.sv
module bscan_tap_tb;
  localparam int N_INT = 47;
  localparam int N_IN  = 33;
  localparam int N_DQ  = 18;
  localparam int LEN   = 117;
  localparam int SW    = 128;
  localparam logic [31:0] IDV = 32'h0001_21B3;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
  logic [N_INT-1:0] core_obs    = 47'h5A3C_0F96_E1D2;
  logic [N_IN-1:0]  pin_in      = 33'h1_2345_6789;
  logic [N_DQ-1:0]  dq_pin_in   = 18'h1C3F1;
  logic [N_DQ-1:0]  core_dq_out = 18'h2A5A5;
  logic             core_dq_oe  = 1'b1;
  logic tdo, tdo_oe, dq_oe;
  logic [N_DQ-1:0] dq_out;

  int checks = 0;
  int errors = 0;

  always #10 tck = ~tck;

  bscan_tap u_dut (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .core_obs(core_obs),
    .pin_in(pin_in), .dq_pin_in(dq_pin_in), .core_dq_out(core_dq_out),
    .core_dq_oe(core_dq_oe), .tdo(tdo), .tdo_oe(tdo_oe), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  localparam logic [SW-1:0] PAT_A = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
  localparam logic [SW-1:0] PAT_B = 128'h70E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;

  // op[6:4], kind[3:2] (0 bypass, 1 id, 2 boundary), pins[1:0] (0 core, 1 ext, 2 hiz)
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 2'd2, 2'd1}, {3'b100, 2'd2, 2'd0}, {3'b001, 2'd1, 2'd0},
    {3'b010, 2'd2, 2'd2}, {3'b111, 2'd0, 2'd0}, {3'b011, 2'd0, 2'd0},
    {3'b101, 2'd0, 2'd0}, {3'b110, 2'd0, 2'd0}
  };

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk(input logic m, input logic d, output logic o);
    @(negedge tck); #2;
    o = tdo; tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic settle();
    @(negedge tck); #2;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] capt);
    logic o;
    clk(1, 0, o); clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
    for (int i = 0; i < 3; i++) begin
      clk(i == 2, op[i], o); capt[i] = o;
    end
    clk(1, 0, o); clk(0, 0, o);
  endtask

  task automatic scan_dr(input logic [SW-1:0] pat, output logic [SW-1:0] got);
    logic o;
    clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
    for (int i = 0; i < SW; i++) begin
      clk(i == SW-1, pat[i], o); got[i] = o;
    end
    clk(1, 0, o); clk(0, 0, o);
  endtask

  function automatic logic [LEN-1:0] bsr_capture();
    logic [LEN-1:0] v;
    for (int i = 0; i < N_INT; i++) v[i] = core_obs[i];
    for (int i = 0; i < N_IN; i++)  v[47+i] = pin_in[i];
    for (int k = 0; k < N_DQ; k++) begin
      v[80+2*k] = core_dq_out[k];
      v[81+2*k] = dq_pin_in[k];
    end
    v[116] = core_dq_oe;
    return v;
  endfunction

  function automatic logic [SW-1:0] exp_stream(input int kind, input logic [SW-1:0] pat);
    logic [SW-1:0] s;
    logic [LEN-1:0] c;
    c = bsr_capture();
    for (int i = 0; i < SW; i++) begin
      if (kind == 0)      s[i] = (i == 0) ? 1'b0 : pat[i-1];
      else if (kind == 1) s[i] = (i < 32) ? IDV[i] : pat[i-32];
      else                s[i] = (i < LEN) ? c[i] : pat[i-LEN];
    end
    return s;
  endfunction

  function automatic logic [N_DQ:0] exp_ext(input logic [SW-1:0] pat);
    logic [N_DQ:0] r;
    for (int k = 0; k < N_DQ; k++) r[k] = pat[SW-LEN+80+2*k];
    r[N_DQ] = pat[SW-1];
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic o;
    logic [2:0] capt;
    logic [SW-1:0] got;
    logic [N_DQ:0] pins;

    #35;
    // R11 / R10: reset state at the ports
    check("R10 tdo_oe in reset", SW'(tdo_oe), SW'(0));
    check("R11 pins under reset", SW'({dq_oe, dq_out}), SW'({core_dq_oe, core_dq_out}));
    trst_n = 1'b1;
    clk(0, 0, o);

    // R2: IDCODE after reset
    scan_dr(PAT_A, got);
    check("R2 idcode after reset", got, exp_stream(1, PAT_A));

    // R3: capture pattern of the instruction register
    load_ir(3'b100, capt);
    check("R3 IR capture 001", SW'(capt), SW'(3'b001));

    // R4..R9: table walk over every opcode
    foreach (VEC[n]) begin
      int kind, pm;
      kind = int'(VEC[n][3:2]);
      pm   = int'(VEC[n][1:0]);
      load_ir(VEC[n][6:4], capt);
      scan_dr(PAT_A, got);
      check($sformatf("R4 R5 R6 stream op=%b", VEC[n][6:4]), got, exp_stream(kind, PAT_A));
      settle();
      if (pm == 1)      pins = exp_ext(PAT_A);
      else if (pm == 2) pins = {1'b0, core_dq_out};
      else              pins = {core_dq_oe, core_dq_out};
      check($sformatf("R7 R8 R9 pins op=%b", VEC[n][6:4]), SW'({dq_oe, dq_out}), SW'(pins));
    end

    // R8: control cell 0 under EXTEST turns outputs off
    load_ir(3'b000, capt);
    scan_dr(PAT_B, got);
    settle();
    check("R8 ctrl=0 outputs off", SW'({dq_oe, dq_out}), SW'(exp_ext(PAT_B)));

    // R9: SAMPLZ holds outputs off even with control cell 1 preloaded
    scan_dr(PAT_A, got);
    load_ir(3'b010, capt);
    settle();
    check("R9 samplz ignores ctrl=1", SW'({dq_oe, dq_out}), SW'({1'b0, core_dq_out}));

    // R10: tdo_oe timing around Shift-DR entry and in idle
    clk(1, 0, o); clk(0, 0, o); clk(0, 0, o);
    #1;
    check("R10 oe not yet on after rising edge", SW'(tdo_oe), SW'(0));
    settle();
    check("R10 oe on after falling edge", SW'(tdo_oe), SW'(1));
    clk(1, 0, o); clk(1, 0, o); clk(0, 0, o);
    settle();
    check("R10 oe off in idle", SW'(tdo_oe), SW'(0));

    // R1: five ones from Pause-DR under BYPASS reach reset
    load_ir(3'b111, capt);
    clk(1, 0, o); clk(0, 0, o); clk(0, 0, o); clk(1, 0, o); clk(0, 0, o);
    for (int i = 0; i < 5; i++) clk(1, 0, o);
    clk(0, 0, o);
    scan_dr(PAT_A, got);
    check("R1 five tms ones reset to idcode", got, exp_stream(1, PAT_A));

    // R1 / R11: asynchronous reset during EXTEST
    load_ir(3'b000, capt);
    scan_dr(PAT_A, got);
    settle();
    check("R8 extest drives ctrl=1", SW'({dq_oe, dq_out}), SW'(exp_ext(PAT_A)));
    trst_n = 1'b0; tms = 1'b1;
    #3;
    check("R1 async reset restores core pins", SW'({dq_oe, dq_out}), SW'({core_dq_oe, core_dq_out}));
    @(negedge tck);
    trst_n = 1'b1;
    clk(0, 0, o);
    load_ir(3'b000, capt);
    settle();
    check("R11 update stages cleared", SW'({dq_oe, dq_out}), SW'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule